// File: doc/BRIEF.md
# Variable-Length Integer Byte Decoder

This block turns a stream of variable-length integer code bytes back into a 64-bit unsigned value. Each byte carries a 7-bit slice of the value and a flag that says whether another byte follows. The least significant slice arrives first. The block takes one byte per cycle when the input strobe is high and places each slice at its bit position. When the terminating byte arrives, it presents the rebuilt value, the number of bytes that made up the code, and a one-cycle valid pulse.

The block also checks that a code fits in 64 bits. A tenth byte that asks for more bytes, or that carries payload beyond bit 63, produces a one-cycle error pulse instead of a value. The byte after such an error starts a new code. Bytes of one code may be spread over any number of idle cycles.

Top module: `varint_byte_decoder`

## Requirements
- R1: Input byte bit 7 is the continuation flag: 1 means another byte follows and 0 ends the code. Bits 6:0 are payload.
- R2: The payload of the k-th byte of a code (k counted from 0) lands in value bits 7k+6 down to 7k, with its internal bit order kept.
- R3: Continuation flags never appear in the value. For example, bytes 0x80 then 0x00 decode to 0 with length 2.
- R4: `outValid` is high for exactly the one cycle after the clock edge that accepts a terminating byte. In that cycle `outValue` holds the value and `outLength` holds the byte count, from 1 to 10.
- R5: Value bits above the highest received slice read as zero. After a terminating byte, the next accepted byte starts a fresh code.
- R6: A tenth byte that has bit 7 set, or any of bits 6:1 nonzero, raises `outError` for one cycle at the same point where `outValid` would have risen. `outValid` stays low, the partial value is discarded and `outValue` is unchanged. The next byte starts a new code.
- R7: A cycle with `inValid` low changes no state, so idle gaps inside a code do not alter the result. Between valid pulses, `outValue` and `outLength` hold their last values.
- R8: While `rstN` is low, `outValue`, `outLength`, `outValid` and `outError` are all zero, and any partially received code is discarded.
- R9: Byte 0x01 decodes to 64'h1. Bytes B3 98 A7 9D 93 BB 04 decode to 64'h0000_11D9_33A9_CC33 with length 7.
- R10: Nine bytes 0xFF followed by 0x01 decode to all ones with length 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inByte | input | 8 | Code byte: flag in bit 7, payload in bits 6:0 |
| inValid | input | 1 | `inByte` is accepted on this edge |
| outValue | output | 64 | Last decoded value |
| outValid | output | 1 | One-cycle pulse: a new value is present |
| outLength | output | 4 | Byte count of the last decoded code |
| outError | output | 1 | One-cycle pulse: an overlong or oversize code was dropped |

## Verification
The assertions assume that `inByte` is a known value whenever `inValid` is high, and that nothing outside reset alters the byte count. The bench drives inputs only between clock edges and sends every code byte with `inValid` high. It mixes back-to-back bytes, random idle gaps, codes for random values of every length, and malformed ten-byte codes. A behavioural model that builds values with shifts and ORs predicts the outputs, and the bench compares the outputs against it on every cycle.

// File: rtl/varint_dec_pkg.sv
package varint_dec_pkg;
  localparam int VALUE_W   = 64;
  localparam int GROUP_W   = 7;
  localparam int MAX_BYTES = (VALUE_W + GROUP_W - 1) / GROUP_W;
  localparam int TAIL_W    = VALUE_W - GROUP_W * (MAX_BYTES - 1);
  localparam int IDX_W     = $clog2(MAX_BYTES);
  localparam int LEN_W     = $clog2(MAX_BYTES + 1);

  typedef struct packed {
    logic             load;    // accept payload into slice idx
    logic             finish;  // terminating byte: publish and clear
    logic             drop;    // malformed code: clear, publish nothing
    logic [IDX_W-1:0] idx;     // slice number of current byte
  } decCtrl_t;
endpackage

// File: rtl/varint_dec_ctrl.sv
module varint_dec_ctrl
  import varint_dec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       inByte,
  input  logic             inValid,
  output decCtrl_t         ctrl,
  output logic             outValid,
  output logic             outError,
  output logic [LEN_W-1:0] outLength
);
  logic [IDX_W-1:0] byteCnt;
  logic             moreFlag;
  logic             atLast;
  logic             tailBad;
  logic             badByte;

  assign moreFlag = inByte[7];
  assign atLast   = (byteCnt == IDX_W'(MAX_BYTES - 1));
  assign tailBad  = (inByte[GROUP_W-1:TAIL_W] != '0);
  assign badByte  = atLast && (moreFlag || tailBad);

  always_comb begin
    ctrl.idx    = byteCnt;
    ctrl.drop   = inValid && badByte;
    ctrl.load   = inValid && !badByte;
    ctrl.finish = inValid && !badByte && !moreFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt <= '0;
    end else if (ctrl.drop || ctrl.finish) begin
      byteCnt <= '0;
    end else if (ctrl.load) begin
      byteCnt <= byteCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outError  <= 1'b0;
      outLength <= '0;
    end else begin
      outValid <= ctrl.finish;
      outError <= ctrl.drop;
      if (ctrl.finish) outLength <= LEN_W'(byteCnt) + 1'b1;
    end
  end
endmodule

// File: rtl/varint_dec_datapath.sv
module varint_dec_datapath
  import varint_dec_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  decCtrl_t           ctrl,
  input  logic [GROUP_W-1:0] payload,
  output logic [VALUE_W-1:0] outValue
);
  logic [VALUE_W-1:0] accum;
  logic [VALUE_W-1:0] merged;

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_slice
    localparam int LO = g * GROUP_W;
    localparam int W  = (VALUE_W - LO < GROUP_W) ? (VALUE_W - LO) : GROUP_W;
    always_comb begin
      if (ctrl.idx == IDX_W'(g)) merged[LO +: W] = payload[W-1:0];
      else if (ctrl.idx == '0)   merged[LO +: W] = '0;
      else                       merged[LO +: W] = accum[LO +: W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accum <= '0;
    end else if (ctrl.drop || ctrl.finish) begin
      accum <= '0;
    end else if (ctrl.load) begin
      accum <= merged;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValue <= '0;
    else if (ctrl.finish) outValue <= merged;
  end
endmodule

// File: rtl/varint_byte_decoder.sv
module varint_byte_decoder
  import varint_dec_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   inByte,
  input  logic         inValid,
  output logic [63:0]  outValue,
  output logic         outValid,
  output logic [3:0]   outLength,
  output logic         outError
);
  decCtrl_t ctrl;

  varint_dec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inValid(inValid),
    .ctrl(ctrl), .outValid(outValid), .outError(outError), .outLength(outLength)
  );

  varint_dec_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .payload(inByte[GROUP_W-1:0]),
    .outValue(outValue)
  );
endmodule

// File: rtl/varint_dec_checker.sv
module varint_dec_checker (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  inByte,
  input logic        inValid,
  input logic [63:0] outValue,
  input logic        outValid,
  input logic [3:0]  outLength,
  input logic        outError
);
  // R4 / R6: value and error pulses exclude each other
  a_r6_valid_error_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({outValid, outError}));

  // R4 / R1: a value only follows an accepted byte with flag clear
  a_r4_valid_after_last_byte: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid) && !$past(inByte[7]));

  // R7: no pulse without an accepted byte the edge before
  a_r7_idle_no_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |-> !outValid && !outError);

  // R4: length within the legal range on every pulse
  a_r4_length_range: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outLength >= 4'd1) && (outLength <= 4'd10));

  // R2 / R5: single-byte code yields its payload zero-extended
  a_r5_single_byte_value: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLength == 4'd1) |-> outValue == {57'd0, $past(inByte[6:0])});

  // R7 / R6: value holds when no new value is published
  a_r7_value_holds: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outValue));

  // R8: outputs cleared while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      a_r8_reset_clear: assert (outValue == '0 && !outValid && !outError && outLength == '0);
    end
  end
endmodule

bind varint_byte_decoder varint_dec_checker u_chk (.*);

// File: tb/varint_byte_decoder_tb.sv
`timescale 1ns/1ps
module varint_byte_decoder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  inByte = 8'h00;
  logic        inValid = 1'b0;
  logic [63:0] outValue;
  logic        outValid;
  logic [3:0]  outLength;
  logic        outError;

  int testCount = 0;
  int failCount = 0;
  bit done = 0;

  // model state
  logic [63:0] mAcc = '0;
  int          mCnt = 0;
  logic        eValid = 0, eErr = 0;
  logic [63:0] eVal = '0;
  int          eLen = 0;

  always #4 clk = ~clk;

  varint_byte_decoder u_dut (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inValid(inValid),
    .outValue(outValue), .outValid(outValid), .outLength(outLength), .outError(outError)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: advance the model with the sampled inputs, then compare
  task automatic tick();
    logic [7:0] b;
    logic       v;
    b = inByte;
    v = inValid;
    @(posedge clk);
    #1;
    eValid = 0;
    eErr   = 0;
    if (v) begin
      if (mCnt == 9) begin
        if (b[7] || b[6:1] != 0) begin
          eErr = 1;
        end else begin
          mAcc = mAcc | (64'(b[0]) << 63);
          eValid = 1; eVal = mAcc; eLen = 10;
        end
        mAcc = '0; mCnt = 0;
      end else begin
        mAcc = mAcc | (64'(b[6:0]) << (7 * mCnt));
        if (!b[7]) begin
          eValid = 1; eVal = mAcc; eLen = mCnt + 1;
          mAcc = '0; mCnt = 0;
        end else begin
          mCnt++;
        end
      end
    end
    check("R4 outValid", 64'(outValid), 64'(eValid));
    check("R6 outError", 64'(outError), 64'(eErr));
    check("R2 R7 outValue", outValue, eVal);
    if (eLen != 0) check("R4 R7 outLength", 64'(outLength), 64'(eLen));
  endtask

  task automatic putByte(input logic [7:0] b);
    inByte = b; inValid = 1'b1;
    tick();
    inValid = 1'b0; inByte = $urandom_range(0, 255);
  endtask

  task automatic idle(input int n);
    inValid = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic sendValue(input logic [63:0] v, input int maxGap);
    logic [63:0] r;
    r = v;
    for (int i = 0; i < 10; i++) begin
      if (r < 64'h80) begin
        putByte({1'b0, r[6:0]});
        break;
      end
      putByte({1'b1, r[6:0]});
      r = r >> 7;
      if (maxGap > 0) idle($urandom_range(0, maxGap));
    end
  endtask

  initial begin
    #150000;
    failCount++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [7:0] ex [7];
    ex = '{8'hB3, 8'h98, 8'hA7, 8'h9D, 8'h93, 8'hBB, 8'h04};
    // R8: reset state, also with a byte presented during reset
    inValid = 1'b1; inByte = 8'h05;
    repeat (3) @(posedge clk);
    #1;
    check("R8 outValue", outValue, 64'h0);
    check("R8 outValid", 64'(outValid), 64'h0);
    check("R8 outError", 64'(outError), 64'h0);
    check("R8 outLength", 64'(outLength), 64'h0);
    inValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    idle(2);

    // R9: single byte one
    putByte(8'h01);
    check("R9 value of 0x01", outValue, 64'h1);
    check("R9 length of 0x01", 64'(outLength), 64'd1);
    idle(1);

    // R9 / R7: seven-byte example with gaps
    for (int i = 0; i < 7; i++) begin
      putByte(ex[i]);
      if (i < 6) idle(i % 3);
    end
    check("R9 example value", outValue, 64'h0000_11D9_33A9_CC33);
    check("R9 example length", 64'(outLength), 64'd7);
    idle(3);
    check("R7 value held", outValue, 64'h0000_11D9_33A9_CC33);

    // R3: flag-only bytes
    putByte(8'h80); putByte(8'h00);
    check("R3 flags dropped", outValue, 64'h0);
    check("R3 length", 64'(outLength), 64'd2);

    // R10: maximum value
    for (int i = 0; i < 9; i++) putByte(8'hFF);
    putByte(8'h01);
    check("R10 all ones", outValue, {64{1'b1}});
    check("R10 length", 64'(outLength), 64'd10);

    // R5: short code after long one reads zero above
    putByte(8'h85); putByte(8'h03);
    check("R5 upper bits zero", outValue, 64'h185);

    // R6: tenth byte with flag set, then resync
    for (int i = 0; i < 10; i++) putByte(8'h81);
    check("R6 error on flag", 64'(outError), 64'h1);
    check("R6 value unchanged", outValue, 64'h185);
    putByte(8'h05);
    check("R6 resync value", outValue, 64'h5);
    check("R6 resync length", 64'(outLength), 64'd1);

    // R6: tenth byte with extra payload bits
    for (int i = 0; i < 9; i++) putByte(8'hFF);
    putByte(8'h02);
    check("R6 error on tail bits", 64'(outError), 64'h1);
    putByte(8'h7F);
    check("R6 resync after tail", outValue, 64'h7F);

    // R1 / R2 / R5: random values of varied length, some with gaps
    for (int n = 0; n < 300; n++) begin
      logic [63:0] v;
      int sh;
      sh = $urandom_range(0, 63);
      v = {$urandom, $urandom};
      v = v >> sh;
      sendValue(v, (n % 2) ? 3 : 0);
      check("R2 random value", outValue, v);
    end

    // R4: back-to-back single-byte codes
    for (int n = 0; n < 20; n++) putByte(8'(n));
    idle(2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule